// File: doc/BRIEF.md
# Priority-ordered pending virtual interrupt queue

This block keeps a small, ordered set of pending virtual interrupts waiting to be placed into a core's delivery slots. Each entry records an interrupt number, a 5-bit urgency level (smaller is more urgent), a flag saying the entry was delivered before, an enable bit, a per-core target mask and an owning core. The queue is always kept sorted: urgency first, and among equal urgency, previously delivered entries ahead of fresh ones. New entries land behind every entry they tie with.

Four commands act on the queue: insert one entry, drop the entry with a given number, sweep the queue and drop entries the surrounding logic reports as no longer pending, and pick up to N entries that a given core may take, where N is its count of free delivery slots. Picked entries leave the queue marked as delivered and are handed out one per transfer on a valid/ready port. Entries the requesting core may not take stay in place, in their order. Inserts walk the new entry up from the tail one slot per cycle; the three other commands share one scan that visits each entry once and closes the gaps behind it. A read port shows any slot's contents.

Top module: `vint_pend_queue`

## Requirements
- R1: After reset the queue holds no entry, `busy`, `out_valid` and `chk_valid` are low, and every slot reads back a priority byte of 0xF8 (stored level 0x1F).
- R2: Slot 0 is the head; across occupied slots the stored level never decreases from head to tail.
- R3: Among entries with the same level, every entry with the delivered flag set sits ahead of every entry with it clear.
- R4: An inserted entry is placed behind all queued entries that have both the same level and the same delivered flag.
- R5: Inserting a number that is already queued is refused: `ins_dup` pulses for one cycle in the cycle after acceptance and the queue is left unchanged (this check wins over R6).
- R6: Inserting into a full queue is refused: `ins_ovf` pulses for one cycle in the cycle after acceptance and the queue is left unchanged.
- R7: A pick for core C with budget N scans from the head and hands out, in queue order, the first N entries that core C may take, each with `out_handled` high; they leave the queue and all other entries keep their relative order; a budget of 0 hands out nothing.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and the output fields hold still.
- R9: An entry with number below 32 may be taken only by its owning core; one with number 32 or above only when enabled and bit C of its target mask is set; numbers below 16 report `out_enable` high regardless of the stored bit.
- R10: The level is stored from bits [7:3] of the written priority byte; the read port returns the stored level in bits [7:3] with bits [2:0] zero.
- R11: At most one command is taken per cycle, with insert before remove before sweep before pick; commands presented while `busy` is high are ignored, so an insert and a pick offered together leave the pick unperformed.
- R12: Removing a number drops the matching entry and keeps the rest in order; a number not in the queue leaves it unchanged.
- R13: A sweep presents each queued number once, head to tail, on `chk_id` with `chk_valid` high, reads `chk_pending` in the same cycle, drops entries answered low and keeps the rest in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request |
| ins_id | input | IDW | Interrupt number to insert |
| ins_prio_byte | input | 8 | Priority byte; bits [7:3] kept |
| ins_handled | input | 1 | Delivered-before flag of the new entry |
| ins_enable | input | 1 | Enable bit of the new entry |
| ins_targets | input | CORES | Target core mask of the new entry |
| ins_owner | input | CW | Owning core of the new entry |
| rm_valid | input | 1 | Remove-by-number request |
| rm_id | input | IDW | Number to remove |
| cln_valid | input | 1 | Sweep request |
| chk_valid | output | 1 | Sweep is asking about `chk_id` |
| chk_id | output | IDW | Number being asked about |
| chk_pending | input | 1 | Same-cycle answer: still pending |
| sel_valid | input | 1 | Pick request |
| sel_core | input | CW | Requesting core |
| sel_free | input | NW | Number of entries the core can take |
| out_valid | output | 1 | A picked entry is offered |
| out_ready | input | 1 | Receiver takes the offered entry |
| out_id | output | IDW | Number of the offered entry |
| out_prio | output | 5 | Stored level of the offered entry |
| out_handled | output | 1 | Delivered flag of the offered entry |
| out_enable | output | 1 | Effective enable of the offered entry |
| out_targets | output | CORES | Target mask of the offered entry |
| out_owner | output | CW | Owning core of the offered entry |
| busy | output | 1 | A command is in progress |
| count | output | NW | Number of queued entries |
| ins_dup | output | 1 | Pulse: insert refused, number already queued |
| ins_ovf | output | 1 | Pulse: insert refused, queue full |
| peek_idx | input | PW | Slot to read |
| peek_valid | output | 1 | Slot is occupied |
| peek_id | output | IDW | Number stored in the slot |
| peek_prio_byte | output | 8 | Stored level shifted left by 3 |
| peek_handled | output | 1 | Delivered flag stored in the slot |

## Verification
Properties hold every cycle on the sorted order and the tie rule while the queue is idle, on refused inserts leaving the count alone, on the output staying put during back-pressure, on every offered entry being one the requesting core may take, and on an insert shutting out a pick offered in the same cycle. Placement behind equal entries, the exact sequence handed out under a budget, what a sweep or removal leaves behind, and the priority-byte round trip depend on the queue's whole history, so only the bench's reference model comparing every slot after each command can show them.

// File: rtl/vpq_pkg.sv
package vpq_pkg;

   localparam int PRIO_W   = 5;
   localparam int PRIO_LSB = 3;

   typedef logic [PRIO_W-1:0] prio_t;

   localparam prio_t PRIO_IDLE = '1;

   typedef enum logic [1:0] {ST_IDLE, ST_INS, ST_SCAN} state_e;
   typedef enum logic [1:0] {SC_RM, SC_CLN, SC_SEL} scan_e;

   // true when a newcomer must be placed ahead of an already queued entry
   function automatic logic goes_before(input prio_t new_pr, input logic new_h,
                                        input prio_t old_pr, input logic old_h);
      return (new_pr < old_pr) || ((new_pr == old_pr) && new_h && !old_h);
   endfunction

endpackage

// File: rtl/vpq_eligible.sv
module vpq_eligible #(
   parameter int IDW   = 10,
   parameter int CORES = 8,
   localparam int CW   = $clog2(CORES)
)(
   input  logic [IDW-1:0]   id,
   input  logic [CW-1:0]    owner,
   input  logic             enable,
   input  logic [CORES-1:0] targets,
   input  logic [CW-1:0]    core,
   output logic             en_eff,
   output logic             ok
);
   localparam int BANKED_LIMIT = 32;
   localparam int ALWAYS_ON    = 16;

   logic banked;

   always_comb begin
      banked = (id < IDW'(BANKED_LIMIT));
      en_eff = enable || (id < IDW'(ALWAYS_ON));
      if (banked) ok = (owner == core);
      else        ok = en_eff && targets[core];
   end

endmodule

// File: rtl/vpq_match.sv
module vpq_match #(
   parameter int DEPTH = 16,
   parameter int IDW   = 10,
   localparam int NW   = $clog2(DEPTH + 1)
)(
   input  logic [DEPTH-1:0][IDW-1:0] ids,
   input  logic [NW-1:0]             count,
   input  logic [IDW-1:0]            key,
   output logic                      hit
);
   logic [DEPTH-1:0] slot_hit;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign slot_hit[i] = (NW'(i) < count) && (ids[i] == key);
   end

   assign hit = |slot_hit;

endmodule

// File: rtl/vint_pend_queue.sv
module vint_pend_queue
   import vpq_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int IDW   = 10,
   parameter int CORES = 8,
   localparam int CW   = $clog2(CORES),
   localparam int PW   = $clog2(DEPTH),
   localparam int NW   = $clog2(DEPTH + 1)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ins_valid,
   input  logic [IDW-1:0]   ins_id,
   input  logic [7:0]       ins_prio_byte,
   input  logic             ins_handled,
   input  logic             ins_enable,
   input  logic [CORES-1:0] ins_targets,
   input  logic [CW-1:0]    ins_owner,
   input  logic             rm_valid,
   input  logic [IDW-1:0]   rm_id,
   input  logic             cln_valid,
   output logic             chk_valid,
   output logic [IDW-1:0]   chk_id,
   input  logic             chk_pending,
   input  logic             sel_valid,
   input  logic [CW-1:0]    sel_core,
   input  logic [NW-1:0]    sel_free,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [IDW-1:0]   out_id,
   output logic [4:0]       out_prio,
   output logic             out_handled,
   output logic             out_enable,
   output logic [CORES-1:0] out_targets,
   output logic [CW-1:0]    out_owner,
   output logic             busy,
   output logic [NW-1:0]    count,
   output logic             ins_dup,
   output logic             ins_ovf,
   input  logic [PW-1:0]    peek_idx,
   output logic             peek_valid,
   output logic [IDW-1:0]   peek_id,
   output logic [7:0]       peek_prio_byte,
   output logic             peek_handled
);

   // elaboration-time parameter checks
   if (DEPTH < 2) begin : g_bad_depth
      $error("vint_pend_queue: DEPTH must be at least 2");
   end
   if (IDW < 6) begin : g_bad_idw
      $error("vint_pend_queue: IDW must reach interrupt number 32");
   end
   if (CORES < 2) begin : g_bad_cores
      $error("vint_pend_queue: CORES must be at least 2");
   end

   // ---------------- storage ----------------
   logic [DEPTH-1:0][IDW-1:0] q_id;
   prio_t                     q_pr [DEPTH];
   logic                      q_h  [DEPTH];
   logic                      q_en [DEPTH];
   logic [CORES-1:0]          q_tg [DEPTH];
   logic [CW-1:0]             q_ow [DEPTH];

   // ---------------- control ----------------
   state_e           st;
   scan_e            mode;
   logic [NW-1:0]    rd_ptr, wr_ptr, taken, sel_n, ins_ptr;
   logic [CW-1:0]    s_core;
   logic [IDW-1:0]   rm_key;

   // entry being inserted
   logic [IDW-1:0]   e_id;
   prio_t            e_pr;
   logic             e_h, e_en;
   logic [CORES-1:0] e_tg;
   logic [CW-1:0]    e_ow;

   logic [PW-1:0]    cur, wslot, prv, cslot;
   logic             in_range, elig, en_eff, take, drop, advance;
   logic             dup_hit, shift_up;
   logic             unused_prio_lsbs;

   assign unused_prio_lsbs = ^ins_prio_byte[PRIO_LSB-1:0];

   assign cur   = PW'(rd_ptr);
   assign cslot = PW'(wr_ptr);
   assign wslot = PW'(ins_ptr);
   assign prv   = PW'(ins_ptr - NW'(1));

   assign busy     = (st != ST_IDLE);
   assign in_range = (rd_ptr < count);
   assign shift_up = (ins_ptr != '0) && goes_before(e_pr, e_h, q_pr[prv], q_h[prv]);

   vpq_match #(.DEPTH(DEPTH), .IDW(IDW)) u_match (
      .ids   (q_id),
      .count (count),
      .key   (ins_id),
      .hit   (dup_hit)
   );

   vpq_eligible #(.IDW(IDW), .CORES(CORES)) u_elig (
      .id      (q_id[cur]),
      .owner   (q_ow[cur]),
      .enable  (q_en[cur]),
      .targets (q_tg[cur]),
      .core    (s_core),
      .en_eff  (en_eff),
      .ok      (elig)
   );

   always_comb begin
      take = (mode == SC_SEL) && elig && (taken < sel_n);
      unique case (mode)
         SC_RM:   drop = (q_id[cur] == rm_key);
         SC_CLN:  drop = !chk_pending;
         default: drop = take;
      endcase
      out_valid = (st == ST_SCAN) && in_range && take;
      advance   = !(out_valid && !out_ready);
      chk_valid = (st == ST_SCAN) && in_range && (mode == SC_CLN);
   end

   assign chk_id      = q_id[cur];
   assign out_id      = q_id[cur];
   assign out_prio    = q_pr[cur];
   assign out_handled = take;
   assign out_enable  = en_eff;
   assign out_targets = q_tg[cur];
   assign out_owner   = q_ow[cur];

   assign peek_valid     = (NW'(peek_idx) < count);
   assign peek_id        = q_id[peek_idx];
   assign peek_prio_byte = {q_pr[peek_idx], {PRIO_LSB{1'b0}}};
   assign peek_handled   = q_h[peek_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         mode    <= SC_RM;
         count   <= '0;
         rd_ptr  <= '0;
         wr_ptr  <= '0;
         taken   <= '0;
         sel_n   <= '0;
         ins_ptr <= '0;
         s_core  <= '0;
         rm_key  <= '0;
         ins_dup <= 1'b0;
         ins_ovf <= 1'b0;
         e_id    <= '0;
         e_pr    <= PRIO_IDLE;
         e_h     <= 1'b0;
         e_en    <= 1'b0;
         e_tg    <= '0;
         e_ow    <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            q_id[i] <= '0;
            q_pr[i] <= PRIO_IDLE;
            q_h[i]  <= 1'b0;
            q_en[i] <= 1'b0;
            q_tg[i] <= '0;
            q_ow[i] <= '0;
         end
      end else begin
         ins_dup <= 1'b0;
         ins_ovf <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (ins_valid) begin
                  if (dup_hit) begin
                     ins_dup <= 1'b1;
                  end else if (count == NW'(DEPTH)) begin
                     ins_ovf <= 1'b1;
                  end else begin
                     e_id    <= ins_id;
                     e_pr    <= ins_prio_byte[PRIO_LSB +: PRIO_W];
                     e_h     <= ins_handled;
                     e_en    <= ins_enable;
                     e_tg    <= ins_targets;
                     e_ow    <= ins_owner;
                     ins_ptr <= count;
                     st      <= ST_INS;
                  end
               end else if (rm_valid) begin
                  mode   <= SC_RM;
                  rm_key <= rm_id;
                  rd_ptr <= '0;
                  wr_ptr <= '0;
                  st     <= ST_SCAN;
               end else if (cln_valid) begin
                  mode   <= SC_CLN;
                  rd_ptr <= '0;
                  wr_ptr <= '0;
                  st     <= ST_SCAN;
               end else if (sel_valid) begin
                  mode   <= SC_SEL;
                  s_core <= sel_core;
                  sel_n  <= sel_free;
                  taken  <= '0;
                  rd_ptr <= '0;
                  wr_ptr <= '0;
                  st     <= ST_SCAN;
               end
            end
            ST_INS: begin
               if (shift_up) begin
                  q_id[wslot] <= q_id[prv];
                  q_pr[wslot] <= q_pr[prv];
                  q_h[wslot]  <= q_h[prv];
                  q_en[wslot] <= q_en[prv];
                  q_tg[wslot] <= q_tg[prv];
                  q_ow[wslot] <= q_ow[prv];
                  ins_ptr     <= ins_ptr - NW'(1);
               end else begin
                  q_id[wslot] <= e_id;
                  q_pr[wslot] <= e_pr;
                  q_h[wslot]  <= e_h;
                  q_en[wslot] <= e_en;
                  q_tg[wslot] <= e_tg;
                  q_ow[wslot] <= e_ow;
                  count       <= count + NW'(1);
                  st          <= ST_IDLE;
               end
            end
            ST_SCAN: begin
               if (!in_range) begin
                  count <= wr_ptr;
                  st    <= ST_IDLE;
               end else if (advance) begin
                  if (drop) begin
                     if (mode == SC_SEL) taken <= taken + NW'(1);
                  end else begin
                     q_id[cslot] <= q_id[cur];
                     q_pr[cslot] <= q_pr[cur];
                     q_h[cslot]  <= q_h[cur];
                     q_en[cslot] <= q_en[cur];
                     q_tg[cslot] <= q_tg[cur];
                     q_ow[cslot] <= q_ow[cur];
                     wr_ptr      <= wr_ptr + NW'(1);
                  end
                  rd_ptr <= rd_ptr + NW'(1);
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // ---------------- assertions ----------------
   for (genvar i = 0; i < DEPTH - 1; i++) begin : g_order_chk
      p_sorted_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (st == ST_IDLE && NW'(i + 1) < count) |-> (q_pr[i] <= q_pr[i+1]))
         else $error("R2 order broken at slot %0d", i);

      p_tie_handled_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (st == ST_IDLE && NW'(i + 1) < count && q_pr[i] == q_pr[i+1]) |-> (q_h[i] || !q_h[i+1]))
         else $error("R3 tie order broken at slot %0d", i);
   end

   p_dup_keeps_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ins_dup |-> ($stable(count) && !busy))
      else $error("R5 refused duplicate changed the queue");

   p_ovf_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ins_ovf |-> (count == NW'(DEPTH) && $stable(count) && !busy))
      else $error("R6 overflow flagged while not full");

   p_hold_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_id) && $stable(out_prio)
                                     && $stable(out_targets) && $stable(out_owner)))
      else $error("R8 offered entry moved under back-pressure");

   p_elig_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_id < IDW'(32)) ? (out_owner == s_core)
                                          : (out_enable && out_targets[s_core])))
      else $error("R9 offered entry not takeable by the core");

   p_one_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && ins_valid) |=> !out_valid)
      else $error("R11 pick ran alongside an insert");

endmodule

// File: tb/tb_vint_pend_queue.sv
module tb_vint_pend_queue;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 16, IDW = 10, CORES = 8, CW = 3, PW = 4, NW = 5;
   localparam int WATCHDOG = 150000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ins_valid = 0, ins_handled = 0, ins_enable = 0;
   logic [IDW-1:0] ins_id = '0, rm_id = '0;
   logic [7:0] ins_prio_byte = '0;
   logic [CORES-1:0] ins_targets = '0;
   logic [CW-1:0] ins_owner = '0, sel_core = '0;
   logic rm_valid = 0, cln_valid = 0, sel_valid = 0, out_ready = 0;
   logic [NW-1:0] sel_free = '0;
   logic chk_valid, chk_pending, out_valid, out_handled, out_enable, busy, ins_dup, ins_ovf;
   logic [IDW-1:0] chk_id, out_id, peek_id;
   logic [4:0] out_prio;
   logic [CORES-1:0] out_targets;
   logic [CW-1:0] out_owner;
   logic [NW-1:0] count;
   logic [PW-1:0] peek_idx = '0;
   logic peek_valid, peek_handled;
   logic [7:0] peek_prio_byte;

   int checks = 0, fails = 0;
   bit pend_tab [1024];

   // reference model
   logic [IDW-1:0] m_id [DEPTH];
   logic [4:0] m_pr [DEPTH];
   bit m_h [DEPTH], m_en [DEPTH];
   logic [CORES-1:0] m_tg [DEPTH];
   logic [CW-1:0] m_ow [DEPTH];
   int m_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always_comb chk_pending = pend_tab[chk_id];

   vint_pend_queue #(.DEPTH(DEPTH), .IDW(IDW), .CORES(CORES)) dut (
      .clk(clk), .rst_n(rst_n),
      .ins_valid(ins_valid), .ins_id(ins_id), .ins_prio_byte(ins_prio_byte),
      .ins_handled(ins_handled), .ins_enable(ins_enable), .ins_targets(ins_targets),
      .ins_owner(ins_owner), .rm_valid(rm_valid), .rm_id(rm_id), .cln_valid(cln_valid),
      .chk_valid(chk_valid), .chk_id(chk_id), .chk_pending(chk_pending),
      .sel_valid(sel_valid), .sel_core(sel_core), .sel_free(sel_free),
      .out_valid(out_valid), .out_ready(out_ready), .out_id(out_id), .out_prio(out_prio),
      .out_handled(out_handled), .out_enable(out_enable), .out_targets(out_targets),
      .out_owner(out_owner), .busy(busy), .count(count), .ins_dup(ins_dup), .ins_ovf(ins_ovf),
      .peek_idx(peek_idx), .peek_valid(peek_valid), .peek_id(peek_id),
      .peek_prio_byte(peek_prio_byte), .peek_handled(peek_handled)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   function automatic bit m_before(input logic [4:0] pa, input bit ha, input logic [4:0] pb, input bit hb);
      return (pa < pb) || (pa == pb && ha && !hb);
   endfunction

   function automatic bit m_elig(input int k, input int core);
      if (m_id[k] < 32) return m_ow[k] == 3'(core);
      return (m_en[k] || m_id[k] < 16) && m_tg[k][core];
   endfunction

   task automatic m_copy(input int dst, input int src);
      m_id[dst] = m_id[src]; m_pr[dst] = m_pr[src]; m_h[dst] = m_h[src];
      m_en[dst] = m_en[src]; m_tg[dst] = m_tg[src]; m_ow[dst] = m_ow[src];
   endtask

   task automatic check_all(input string tag);
      check(count == NW'(m_cnt), tag, "entry count", 64'(count), 64'(m_cnt));
      for (int k = 0; k < m_cnt; k++) begin
         peek_idx = PW'(k);
         #1;
         check(peek_valid && peek_id == m_id[k] && peek_prio_byte == {m_pr[k], 3'b000}
               && peek_handled == m_h[k], tag, $sformatf("slot %0d id/prio/handled", k),
               64'({peek_id, peek_prio_byte, peek_handled}), 64'({m_id[k], m_pr[k], 3'b000, m_h[k]}));
      end
   endtask

   task automatic wait_idle;
      while (busy) @(negedge clk);
   endtask

   task automatic do_insert(input logic [IDW-1:0] id, input logic [7:0] pb, input bit h, input bit en,
                            input logic [CORES-1:0] tg, input logic [CW-1:0] ow);
      int res;
      int pos;
      bit d, o;
      res = 0;
      for (int k = 0; k < m_cnt; k++) if (m_id[k] == id) res = 1;
      if (res == 0 && m_cnt == DEPTH) res = 2;
      if (res == 0) begin
         pos = m_cnt;
         while (pos > 0 && m_before(pb[7:3], h, m_pr[pos-1], m_h[pos-1])) begin
            m_copy(pos, pos - 1);
            pos--;
         end
         m_id[pos] = id; m_pr[pos] = pb[7:3]; m_h[pos] = h; m_en[pos] = en; m_tg[pos] = tg; m_ow[pos] = ow;
         m_cnt++;
      end
      @(negedge clk);
      ins_id = id; ins_prio_byte = pb; ins_handled = h; ins_enable = en;
      ins_targets = tg; ins_owner = ow; ins_valid = 1;
      @(negedge clk);
      ins_valid = 0;
      d = ins_dup; o = ins_ovf;
      check(d == (res == 1), "R5", "duplicate flag", 64'(d), 64'(res == 1));
      check(o == (res == 2), "R6", "overflow flag", 64'(o), 64'(res == 2));
      wait_idle();
      check_all("R2 R3 R4 R10");
   endtask

   task automatic do_remove(input logic [IDW-1:0] id);
      int w;
      w = 0;
      for (int k = 0; k < m_cnt; k++) if (m_id[k] != id) begin m_copy(w, k); w++; end
      m_cnt = w;
      @(negedge clk); rm_id = id; rm_valid = 1;
      @(negedge clk); rm_valid = 0;
      wait_idle();
      check_all("R12");
   endtask

   task automatic do_clean;
      int w, seen, old;
      logic [IDW-1:0] old_id [DEPTH];
      for (int k = 0; k < m_cnt; k++) begin
         pend_tab[m_id[k]] = ($urandom_range(0, 2) != 0);
         old_id[k] = m_id[k];
      end
      old = m_cnt;
      w = 0;
      for (int k = 0; k < m_cnt; k++) if (pend_tab[m_id[k]]) begin m_copy(w, k); w++; end
      m_cnt = w;
      seen = 0;
      @(negedge clk); cln_valid = 1;
      @(negedge clk); cln_valid = 0;
      while (busy) begin
         if (chk_valid) begin
            check(seen < old && chk_id == old_id[seen < old ? seen : 0], "R13", "swept number order",
                  64'(chk_id), 64'(old_id[seen < old ? seen : 0]));
            seen++;
         end
         @(negedge clk);
      end
      check(seen == old, "R13", "numbers presented", 64'(seen), 64'(old));
      check_all("R13");
   endtask

   task automatic do_select(input int core, input int n);
      logic [IDW-1:0] x_id [DEPTH];
      logic [4:0] x_pr [DEPTH];
      bit x_en [DEPTH];
      int nexp, w, got, ix;
      bit stalled;
      logic [IDW-1:0] stall_id;
      nexp = 0; w = 0; got = 0; stalled = 0; stall_id = '0;
      for (int k = 0; k < m_cnt; k++) begin
         if (nexp < n && m_elig(k, core)) begin
            x_id[nexp] = m_id[k]; x_pr[nexp] = m_pr[k]; x_en[nexp] = m_en[k] || (m_id[k] < 16);
            nexp++;
         end else begin
            m_copy(w, k); w++;
         end
      end
      m_cnt = w;
      @(negedge clk); sel_core = CW'(core); sel_free = NW'(n); sel_valid = 1;
      @(negedge clk); sel_valid = 0;
      while (busy) begin
         if (stalled)
            check(out_valid && out_id == stall_id, "R8", "held entry", 64'(out_id), 64'(stall_id));
         out_ready = ($urandom_range(0, 3) != 0);
         if (out_valid) begin
            ix = (got < nexp) ? got : 0;
            if (out_ready) begin
               check(got < nexp && out_id == x_id[ix] && out_prio == x_pr[ix] && out_handled,
                     "R7 R9", "picked entry", 64'({out_id, out_prio, out_handled}),
                     64'({x_id[ix], x_pr[ix], 1'b1}));
               check(out_enable == x_en[ix], "R9", "effective enable", 64'(out_enable), 64'(x_en[ix]));
               got++;
               stalled = 0;
            end else begin
               stalled = 1; stall_id = out_id;
            end
         end else stalled = 0;
         @(negedge clk);
      end
      out_ready = 0;
      check(got == nexp, "R7", "entries handed out", 64'(got), 64'(nexp));
      check_all("R7");
   endtask

   // insert and pick offered together, pick held while busy: only the insert happens
   task automatic do_collide;
      bit saw_busy, saw_out;
      int pos;
      saw_busy = 0; saw_out = 0;
      pos = m_cnt;
      while (pos > 0 && m_before(5'd0, 1'b1, m_pr[pos-1], m_h[pos-1])) begin m_copy(pos, pos - 1); pos--; end
      m_id[pos] = 10'd500; m_pr[pos] = 5'd0; m_h[pos] = 1; m_en[pos] = 1; m_tg[pos] = 8'hFF; m_ow[pos] = 3'd0;
      m_cnt++;
      @(negedge clk);
      ins_id = 10'd500; ins_prio_byte = 8'h07; ins_handled = 1; ins_enable = 1;
      ins_targets = 8'hFF; ins_owner = 3'd0; ins_valid = 1;
      sel_core = 3'd0; sel_free = NW'(DEPTH); sel_valid = 1;
      @(negedge clk);
      ins_valid = 0;
      while (busy) begin
         saw_busy = 1;
         if (out_valid) saw_out = 1;
         @(negedge clk);
      end
      sel_valid = 0;
      check(saw_busy, "R11", "busy during shifting insert", 64'(saw_busy), 64'(1));
      check(!saw_out, "R11", "pick suppressed", 64'(saw_out), 64'(0));
      check_all("R11");
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      checks++; fails++;
      $display("FAIL R11 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int op;
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check(count == '0 && !busy && !out_valid && !chk_valid, "R1", "idle after reset",
            64'({count, busy, out_valid, chk_valid}), 64'(0));
      for (int k = 0; k < DEPTH; k += 5) begin
         peek_idx = PW'(k); #1;
         check(!peek_valid && peek_prio_byte == 8'hF8, "R1", $sformatf("slot %0d reset level", k),
               64'({peek_valid, peek_prio_byte}), 64'(8'hF8));
      end
      // R2 R3 R4 R10: ties, handled ordering, low bits dropped
      do_insert(10'd40, 8'h48, 0, 1, 8'h01, 3'd0);
      do_insert(10'd41, 8'h4F, 0, 1, 8'h02, 3'd0);
      do_insert(10'd42, 8'h49, 1, 1, 8'h04, 3'd0);
      do_insert(10'd43, 8'h20, 0, 0, 8'h08, 3'd0);
      do_insert(10'd5,  8'h48, 1, 0, 8'h00, 3'd3);
      peek_idx = 4'd0; #1;
      check(peek_prio_byte == 8'h20, "R10", "byte round trip", 64'(peek_prio_byte), 64'(8'h20));
      // R5 duplicate
      do_insert(10'd41, 8'h00, 1, 1, 8'hFF, 3'd0);
      // R12 remove present and absent
      do_remove(10'd41);
      do_remove(10'd99);
      // R6 fill then overflow
      for (int k = 0; m_cnt < DEPTH; k++)
         do_insert(10'(200 + k), 8'(k * 8), 1'(k % 2), 1, 8'(1 << (k % 8)), 3'(k % 8));
      do_insert(10'd300, 8'h00, 1, 1, 8'hFF, 3'd0);
      // R7 zero budget, then partial budgets
      do_select(3, 0);
      do_select(3, 2);
      do_select(0, 4);
      do_clean();
      do_collide();
      // random mix
      for (int it = 0; it < 400; it++) begin
         op = $urandom_range(0, 9);
         if (op < 5)
            do_insert(10'($urandom_range(0, 63)), 8'($urandom_range(0, 3) * 8 + $urandom_range(0, 7)),
                      1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)),
                      3'($urandom_range(0, 7)));
         else if (op == 5)
            do_remove((m_cnt > 0 && $urandom_range(0, 1) == 1) ? m_id[$urandom_range(0, m_cnt - 1)]
                                                                 : 10'($urandom_range(0, 63)));
         else if (op == 6)
            do_clean();
         else
            do_select($urandom_range(0, 7), $urandom_range(0, 5));
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule